// File: doc/BRIEF.md
# Triple Scan-Chain Compare and Repair Controller

This block supervises a design built as three redundant copies. Each copy has its own capture/shift scan chain, and the chain samples the module and voter values inside that copy. The controller runs a loop that never ends. It pulses a capture enable for one cycle. It then holds a shift enable while the three chains move out together, one position per cycle. Each cycle it compares the three serial bits. When one bit disagrees with the other two, the copy that owns that bit is the suspect.

The first positions of every chain carry the controller's own outputs. A disagreement at one of those positions asks for the controller to be reconfigured, and the controller then resets itself. Disagreements further down the chain count against the suspect copy, and a second counter counts every disagreement. When a copy's count goes past its limit, the pass stops early and a request names that copy's area. When the overall count goes past its own limit, a request for the whole device is raised instead. Each request is held until the acknowledge input is seen. A fresh capture then starts a new pass. The user logic keeps running the whole time.

Top module: `scan_cmp_ctrl`

## Requirements
- R1: In the first cycle after reset is released, capture_o is 1 for exactly one cycle. When the chain holds no disagreement, a capture pulse follows straight after every complete shift pass, so the loop repeats without end.
- R2: capture_o and shift_o are never 1 together. When no request interrupts a pass, shift_o stays at 1 for exactly CHAIN_LEN consecutive cycles after each capture pulse. The chain position read in shift cycle k is k, counting from 0.
- R3: The suspect copy is the index i of the so_i bit that differs from the other two. The area code of an area request is i, using the values 0, 1 and 2. The code 3 is never produced.
- R4: A disagreement at a chain position below CTRL_BITS raises ctrl_req_o from the next cycle. ctrl_req_o stays at 1 until req_ack_i is seen. In the cycle after the acknowledge, ctrl_rst_o is 1 for one cycle, and it clears every counter. A capture pulse follows.
- R5: When a disagreement is the (X_TH+1)-th one charged to the same copy within one pass, shifting stops. From the next cycle area_req_o is 1, with area_code_o set to that copy.
- R6: The per-copy counters are cleared at the end of every pass, whether the pass ends at the last chain position or on a request.
- R7: When a disagreement outside the controller positions is the (Y_TH+1)-th one since the overall counter was last cleared, dev_req_o is raised from the next cycle. If the same disagreement also crosses the per-copy limit, the device request wins and no area request is raised.
- R8: A request stays at 1, with a stable area code, until req_ack_i is seen. After an area or device acknowledge, capture_o is 1 in the next cycle.
- R9: The overall counter keeps its value from one pass to the next. Only a device acknowledge or a controller reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| so_i | input | 3 | Serial outputs of the three scan chains, bit i from copy i |
| req_ack_i | input | 1 | Acknowledge for the pending request |
| capture_o | output | 1 | Capture enable for all three chains |
| shift_o | output | 1 | Shift enable for all three chains |
| area_req_o | output | 1 | Request to reconfigure one copy's area |
| area_code_o | output | 2 | Copy whose area is to be reconfigured |
| ctrl_req_o | output | 1 | Request to reconfigure the controller |
| ctrl_rst_o | output | 1 | Reset pulse for the controller |
| dev_req_o | output | 1 | Request to reconfigure the whole device |

## Verification
Two things can land on the same shift step. The first is a copy's count going past X_TH, and the second is the overall count going past Y_TH. The bench sets up that collision by charging the same copy X_TH times in one pass after placing disagreements spread across copies and passes. It then checks that only dev_req_o rises. A second collision puts a disagreement on the last chain position, where the end of the pass meets the counting. The result is judged by whether the next cycle shows a capture or a request.

// File: rtl/scan_cmp_pkg.sv
package scan_cmp_pkg;
  typedef enum logic [2:0] {
    ST_CAP, ST_SHF, ST_AREQ, ST_CREQ, ST_CRST, ST_DREQ
  } ctl_st_e;
endpackage

// File: rtl/scan_vote.sv
module scan_vote (
  input  logic [2:0] bits_i,
  output logic       mis_o,
  output logic [1:0] sus_o
);
  always_comb begin
    mis_o = !((bits_i[0] == bits_i[1]) && (bits_i[1] == bits_i[2]));
    if (bits_i[0] == bits_i[1])      sus_o = 2'd2;
    else if (bits_i[0] == bits_i[2]) sus_o = 2'd1;
    else                             sus_o = 2'd0;
  end
endmodule

// File: rtl/mis_ctr.sv
module mis_ctr #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/scan_cmp_ctrl.sv
module scan_cmp_ctrl
  import scan_cmp_pkg::*;
#(
  parameter int CHAIN_LEN = 16,
  parameter int CTRL_BITS = 2,
  parameter int X_TH      = 2,
  parameter int Y_TH      = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] so_i,
  input  logic       req_ack_i,
  output logic       capture_o,
  output logic       shift_o,
  output logic       area_req_o,
  output logic [1:0] area_code_o,
  output logic       ctrl_req_o,
  output logic       ctrl_rst_o,
  output logic       dev_req_o
);
  localparam int PW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam int DW = $clog2(X_TH + 2);
  localparam int GW = $clog2(Y_TH + 2);

  ctl_st_e st_q, st_d;
  logic [PW-1:0] pos_q;
  logic [1:0]    code_q;
  logic          mis, ctrl_zone, hit, dom_over, glob_over, last_pos;
  logic [1:0]    sus;
  logic [DW-1:0] dom_cnt [3];
  logic [DW-1:0] dom_sel;
  logic [GW-1:0] glob_cnt;
  logic          dom_clr, glob_clr;

  scan_vote u_vote (.bits_i(so_i), .mis_o(mis), .sus_o(sus));

  assign ctrl_zone = 32'(pos_q) < CTRL_BITS;
  assign last_pos  = 32'(pos_q) == CHAIN_LEN - 1;
  assign hit       = (st_q == ST_SHF) && mis && !ctrl_zone;

  for (genvar g = 0; g < 3; g++) begin : g_dom
    mis_ctr #(.W(DW)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (dom_clr),
      .inc_i (hit && (sus == 2'(g))),
      .cnt_o (dom_cnt[g])
    );
  end

  mis_ctr #(.W(GW)) u_glob (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (glob_clr),
    .inc_i (hit),
    .cnt_o (glob_cnt)
  );

  always_comb begin
    case (sus)
      2'd0:    dom_sel = dom_cnt[0];
      2'd1:    dom_sel = dom_cnt[1];
      default: dom_sel = dom_cnt[2];
    endcase
  end

  assign dom_over  = dom_sel >= DW'(X_TH);
  assign glob_over = glob_cnt >= GW'(Y_TH);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_CAP:  st_d = ST_SHF;
      ST_SHF: begin
        if (mis && ctrl_zone)      st_d = ST_CREQ;
        else if (hit && glob_over) st_d = ST_DREQ; // device wins the tie
        else if (hit && dom_over)  st_d = ST_AREQ;
        else if (last_pos)         st_d = ST_CAP;
      end
      ST_AREQ: if (req_ack_i) st_d = ST_CAP;
      ST_CREQ: if (req_ack_i) st_d = ST_CRST;
      ST_CRST: st_d = ST_CAP;
      ST_DREQ: if (req_ack_i) st_d = ST_CAP;
      default: st_d = ST_CAP;
    endcase
  end

  assign dom_clr  = ((st_q == ST_SHF) && (st_d != ST_SHF)) || (st_q == ST_CRST);
  assign glob_clr = ((st_q == ST_DREQ) && req_ack_i) || (st_q == ST_CRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CAP;
      pos_q  <= '0;
      code_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_CAP)      pos_q <= '0;
      else if (st_q == ST_SHF) pos_q <= pos_q + 1'b1;
      if (st_q == ST_SHF && st_d == ST_AREQ) code_q <= sus;
    end
  end

  assign capture_o   = st_q == ST_CAP;
  assign shift_o     = st_q == ST_SHF;
  assign area_req_o  = st_q == ST_AREQ;
  assign area_code_o = code_q;
  assign ctrl_req_o  = st_q == ST_CREQ;
  assign ctrl_rst_o  = st_q == ST_CRST;
  assign dev_req_o   = st_q == ST_DREQ;
endmodule

// File: rtl/scan_cmp_chk.sv
module scan_cmp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ack_i,
  input logic       capture_o,
  input logic       shift_o,
  input logic       area_req_o,
  input logic [1:0] area_code_o,
  input logic       ctrl_req_o,
  input logic       ctrl_rst_o,
  input logic       dev_req_o
);
  AST_CAP_SHIFT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(capture_o && shift_o)); // R2
  AST_CAP_THEN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> shift_o); // R1
  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({area_req_o, ctrl_req_o, dev_req_o, ctrl_rst_o})); // R7
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    area_req_o |-> area_code_o != 2'd3); // R3
  AST_AREA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    area_req_o && !req_ack_i |=> area_req_o && $stable(area_code_o)); // R8
  AST_DEV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_o && !req_ack_i |=> dev_req_o); // R8
  AST_CRST_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_req_o && req_ack_i |=> ctrl_rst_o); // R4
  AST_CRST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_o |=> capture_o); // R4
  AST_RECAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (area_req_o || dev_req_o) && req_ack_i |=> capture_o); // R8
endmodule

bind scan_cmp_ctrl scan_cmp_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ack_i  (req_ack_i),
  .capture_o  (capture_o),
  .shift_o    (shift_o),
  .area_req_o (area_req_o),
  .area_code_o(area_code_o),
  .ctrl_req_o (ctrl_req_o),
  .ctrl_rst_o (ctrl_rst_o),
  .dev_req_o  (dev_req_o)
);

// File: tb/tb_scan_cmp_ctrl.sv
`timescale 1ns/1ps
module tb_scan_cmp_ctrl;
  localparam int L  = 16;
  localparam int CB = 2;
  localparam int XT = 2;
  localparam int YT = 5;

  logic clk = 0, rst_n = 0, ack = 0;
  logic [2:0] so = '0;
  logic cap, shf, areq, creq, crst, dreq;
  logic [1:0] code;

  always #2.5 clk = ~clk;

  scan_cmp_ctrl #(.CHAIN_LEN(L), .CTRL_BITS(CB), .X_TH(XT), .Y_TH(YT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .so_i(so), .req_ack_i(ack),
    .capture_o(cap), .shift_o(shf), .area_req_o(areq), .area_code_o(code),
    .ctrl_req_o(creq), .ctrl_rst_o(crst), .dev_req_o(dreq));

  int n_chk = 0, n_bad = 0;
  // model: phase 0 cap,1 shift,2 area req,3 ctrl req,4 ctrl rst,5 dev req
  int ph = 0, pos = 0, glob = 0, mcode = 0, pass = -1, age = 0;
  int cnt [3] = '{0, 0, 0};
  int inj [int];   // key pass*100+pos -> copy to flip
  int n_area = 0, n_dev = 0, n_ctrl = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t act=%0d exp=%0d", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    int prev;
    prev = ph;
    case (ph)
      0: begin ph = 1; pos = 0; pass++; end
      1: begin
        if (!(so[0] == so[1] && so[1] == so[2])) begin
          int d;
          d = (so[0] == so[1]) ? 2 : (so[0] == so[2]) ? 1 : 0;
          if (pos < CB) ph = 3;
          else begin
            if (glob >= YT) ph = 5;
            else if (cnt[d] >= XT) begin ph = 2; mcode = d; end
            cnt[d]++; glob++;
          end
        end
        if (ph == 1) begin
          if (pos == L - 1) ph = 0; else pos++;
        end
        if (ph != 1) cnt = '{0, 0, 0};
      end
      2: if (ack) ph = 0;
      3: if (ack) ph = 4;
      4: begin ph = 0; glob = 0; cnt = '{0, 0, 0}; end
      5: if (ack) begin ph = 0; glob = 0; end
      default: ph = 0;
    endcase
    if (ph == prev && (ph == 2 || ph == 3 || ph == 5)) age++; else age = 0;
    if (ph != prev && ph == 2) n_area++;
    if (ph != prev && ph == 3) n_ctrl++;
    if (ph != prev && ph == 5) n_dev++;
  end

  always @(negedge clk) if (rst_n) begin
    logic b;
    chk("R1 capture", cap, ph == 0);
    chk("R2 shift", shf, ph == 1);
    chk("R5 area_req", areq, ph == 2);
    if (ph == 2) chk("R3 area_code", code, mcode);
    chk("R4 ctrl_req", creq, ph == 3);
    chk("R4 ctrl_rst", crst, ph == 4);
    chk("R7 dev_req", dreq, ph == 5);
    b = 1'(pos ^ pass);
    so = {3{b}};
    if (ph == 1 && inj.exists(pass * 100 + pos)) so[inj[pass * 100 + pos]] = ~b;
    ack = (ph == 2 || ph == 3 || ph == 5) && age == 2;
  end

  initial begin
    // p1: one disagreement on copy 1, counted only (R3)
    inj[1*100+5] = 1;
    // p2: third hit on copy 0 crosses X_TH -> area 0 (R5, R6 pass end)
    inj[2*100+3] = 0; inj[2*100+4] = 0; inj[2*100+6] = 0;
    // p3: overall count carried over (R9): 4 -> 5, then device request (R7)
    inj[3*100+9] = 2; inj[3*100+10] = 2;
    // p4: controller position -> ctrl request and reset (R4)
    inj[4*100+1] = 2;
    // p5/p6: copy 1 counts cleared per pass (R6); collision device vs area (R7)
    inj[5*100+2] = 1; inj[5*100+3] = 1;
    inj[6*100+2] = 1; inj[6*100+3] = 1; inj[6*100+4] = 0; inj[6*100+5] = 1;
    // p7: disagreement on last position, then plain recapture (R2, R8)
    inj[7*100+15] = 2;
    #1;
    chk("R1 reset capture", cap, 1);
    chk("R1 reset shift", shf, 0);
    chk("R1 reset reqs", {areq, creq, crst, dreq}, 0);
    #11 rst_n = 1;
  end

  initial begin
    int wd;
    wd = 0;
    while (pass < 9 && wd < 20000) begin @(posedge clk); wd++; end
    @(negedge clk);
    if (wd >= 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", wd, 0);
    end
    chk("R5 area request count", n_area, 1);
    chk("R7 device request count", n_dev, 2);
    chk("R4 ctrl request count", n_ctrl, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule